// File: doc/BRIEF.md
# Center-Aligned Complementary Gate Pulse Generator

This block drives one leg of a voltage-source inverter. A triangular carrier is built by a time-base counter that ramps up from zero to a programmed peak and back down again. The counter advances once per prescaled tick, and the tick comes from two cascaded clock dividers. A compare value, taken from a shadow copy that refreshes only when the carrier returns to zero, is held against the carrier to form a raw pulse that is centred on the carrier's zero point.

A dead-band stage turns that raw pulse into a complementary pair of active-high gate drives. The high-side drive follows the raw pulse and the low-side drive follows its inverse. Each drive's turn-on edge is held back by its own programmable count, so the switch that is turning off always gets time to stop conducting first. Two single-cycle strobes mark the moments the carrier enters zero and enters its peak, so sampling and control logic can align to the carrier.

With a 150 MHz clock and both dividers at unity, a peak value of 1500 gives a 50 kHz carrier and 7500 gives 10 kHz. A turn-on delay count of 75 gives 500 ns of dead time.

Top module: `cpwm_leg`

## Requirements
- R1: Each prescaled tick moves the counter one step. From zero it counts up to `period_i`, then counts down to zero, then counts up again, so one carrier cycle is 2 × `period_i` ticks. `period_i` must be at least 1.
- R2: A tick occurs once every (`hs_div_i`+1) × (`base_div_i`+1) clock cycles. The two divider fields hold their ratio minus one, and 0 means divide by one. The first tick after reset is on clock edge (`hs_div_i`+1) × (`base_div_i`+1).
- R3: The compare value in use is copied from `cmp_i` only on the tick that brings the counter to zero. The value is 0 from reset until the first such tick, and `cmp_i` changes at other times have no effect until then.
- R4: The raw pulse is high while the counter is below the compare value in use. A compare value of 0 keeps it low, and a value at or above `period_i` keeps it high.
- R5: `evt_zero_o` is high for exactly the first clock in which the counter sits at zero after a tick. `evt_peak_o` behaves the same way for the first clock in which the counter sits at `period_i`. Neither strobe fires for the zero held by reset.
- R6: `gate_hi_o` is high in a given cycle exactly when the raw pulse was high at each of the last `rise_dly_i`+1 clock edges.
- R7: `gate_lo_o` is high in a given cycle exactly when the raw pulse was low at each of the last `fall_dly_i`+1 clock edges.
- R8: `gate_hi_o` and `gate_lo_o` are never high in the same cycle.
- R9: A raw pulse, high or low, that lasts fewer than its turn-on delay + 1 clock edges never turns on the corresponding gate.
- R10: A synchronous active-high reset sets the counter to zero counting up and clears the compare value in use. It drives both gates and both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 16 | Carrier peak count |
| base_div_i | input | 3 | Second (base) divider ratio minus one |
| hs_div_i | input | 3 | First (high-speed) divider ratio minus one |
| cmp_i | input | 16 | Next compare value, taken at carrier zero |
| rise_dly_i | input | 10 | High-side turn-on delay in clocks |
| fall_dly_i | input | 10 | Low-side turn-on delay in clocks |
| gate_hi_o | output | 1 | Upper switch drive, active high |
| gate_lo_o | output | 1 | Lower switch drive, active high |
| evt_zero_o | output | 1 | Strobe on entry to carrier zero |
| evt_peak_o | output | 1 | Strobe on entry to carrier peak |

## Verification
The properties assume that `period_i` is non-zero and that `period_i`, both divider fields and both delay counts change only while reset is held. Only `cmp_i` may move while the carrier runs. The stimulus applies each new configuration under reset, then lets the carrier run. In one run it changes the compare value mid-cycle to show that the shadow copy holds until the next zero. The delay and compare settings cover zero dead time, pulses narrower than the dead time, and compare values at zero, at the peak and above it.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    localparam int CNT_W = 16;
    localparam int DIV_W = 3;
    localparam int DB_W  = 10;
    localparam int N_DIV = 2;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        dir_e             dir;
    } tbase_s;

    function automatic tbase_s tb_step(tbase_s cur, logic [CNT_W-1:0] prd);
        tbase_s nxt;
        nxt = cur;
        if (prd == '0) begin
            nxt.cnt = '0;
            nxt.dir = DIR_UP;
        end else if (cur.dir == DIR_UP) begin
            if (cur.cnt >= prd) begin
                nxt.cnt = cur.cnt - 1'b1;
                nxt.dir = DIR_DOWN;
            end else begin
                nxt.cnt = cur.cnt + 1'b1;
            end
        end else begin
            if (cur.cnt == '0) begin
                nxt.cnt = cur.cnt + 1'b1;
                nxt.dir = DIR_UP;
            end else begin
                nxt.cnt = cur.cnt - 1'b1;
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/cpwm_prescale.sv
module cpwm_prescale #(
    parameter int W      = cpwm_pkg::DIV_W,
    parameter int STAGES = cpwm_pkg::N_DIV
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [STAGES-1:0][W-1:0]   lim_i,
    output logic                       tick_o
);

    logic [STAGES:0] en;
    assign en[0]  = 1'b1;
    assign tick_o = en[STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] cnt_q;
        logic         wrap;
        assign wrap      = en[g] && (cnt_q >= lim_i[g]);
        assign en[g+1]   = wrap;
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (en[g]) begin
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             load_o,
    output logic             evt_zero_o,
    output logic             evt_peak_o
);

    tbase_s cur_q, nxt;
    logic   zero_q, peak_q;

    always_comb nxt = tb_step(cur_q, period_i);

    assign load_o     = tick_i && (nxt.cnt == '0);
    assign cnt_o      = cur_q.cnt;
    assign evt_zero_o = zero_q;
    assign evt_peak_o = peak_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '{cnt: '0, dir: DIR_UP};
            zero_q <= 1'b0;
            peak_q <= 1'b0;
        end else begin
            if (tick_i) cur_q <= nxt;
            zero_q <= tick_i && (nxt.cnt == '0);
            peak_q <= tick_i && (nxt.cnt == period_i);
        end
    end

endmodule

// File: rtl/cpwm_compare.sv
module cpwm_compare
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cmp_act_o,
    output logic             raw_o
);

    logic [CNT_W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst)         act_q <= '0;
        else if (load_i) act_q <= cmp_i;
    end

    assign cmp_act_o = act_q;
    assign raw_o     = (act_q >= period_i) || (cnt_i < act_q);

endmodule

// File: rtl/cpwm_edge_delay.sv
module cpwm_edge_delay #(
    parameter int W = cpwm_pkg::DB_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         level_i,
    input  logic [W-1:0] delay_i,
    output logic         out_o
);

    logic [W-1:0] run_q;
    logic         out_q;

    always_ff @(posedge clk) begin
        if (rst || !level_i) begin
            run_q <= '0;
            out_q <= 1'b0;
        end else if (run_q >= delay_i) begin
            out_q <= 1'b1;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign out_o = out_q;

endmodule

// File: rtl/cpwm_leg.sv
module cpwm_leg
    import cpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_i,
    input  logic [DIV_W-1:0] base_div_i,
    input  logic [DIV_W-1:0] hs_div_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [DB_W-1:0]  rise_dly_i,
    input  logic [DB_W-1:0]  fall_dly_i,
    output logic             gate_hi_o,
    output logic             gate_lo_o,
    output logic             evt_zero_o,
    output logic             evt_peak_o
);

    localparam int N_GATE = 2;

    logic                        tick_w;
    logic                        load_w;
    logic                        raw_w;
    logic [CNT_W-1:0]            cnt_w;
    logic [CNT_W-1:0]            cmp_act_w;
    logic [N_DIV-1:0][DIV_W-1:0] div_lim;
    logic [N_GATE-1:0]           gate_lvl;
    logic [N_GATE-1:0]           gate_out;
    logic [N_GATE-1:0][DB_W-1:0] gate_dly;

    assign div_lim = {base_div_i, hs_div_i};

    cpwm_prescale #(.W(DIV_W), .STAGES(N_DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .lim_i  (div_lim),
        .tick_o (tick_w)
    );

    cpwm_timebase u_tb (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_w),
        .period_i   (period_i),
        .cnt_o      (cnt_w),
        .load_o     (load_w),
        .evt_zero_o (evt_zero_o),
        .evt_peak_o (evt_peak_o)
    );

    cpwm_compare u_cmp (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_w),
        .cmp_i     (cmp_i),
        .cnt_i     (cnt_w),
        .period_i  (period_i),
        .cmp_act_o (cmp_act_w),
        .raw_o     (raw_w)
    );

    assign gate_lvl = {~raw_w, raw_w};
    assign gate_dly = {fall_dly_i, rise_dly_i};

    for (genvar s = 0; s < N_GATE; s++) begin : g_side
        cpwm_edge_delay #(.W(DB_W)) u_dly (
            .clk     (clk),
            .rst     (rst),
            .level_i (gate_lvl[s]),
            .delay_i (gate_dly[s]),
            .out_o   (gate_out[s])
        );
    end

    assign gate_hi_o = gate_out[0];
    assign gate_lo_o = gate_out[1];

endmodule

// File: rtl/cpwm_leg_chk.sv
module cpwm_leg_chk
    import cpwm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] period,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp_act,
    input logic [DB_W-1:0]  rise_dly,
    input logic [DB_W-1:0]  fall_dly,
    input logic             raw,
    input logic             hi,
    input logic             lo,
    input logic             ez,
    input logic             ep
);

    logic [DB_W:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || hi || lo)  gap_q <= '0;
        else if (gap_q != '1) gap_q <= gap_q + 1'b1;
    end

    a_r1_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= period);

    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

    a_r3_shadow: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cmp_act != $past(cmp_act)) |-> cnt == '0);

    a_r4_floor: assert property (@(posedge clk) disable iff (rst)
        (cmp_act == '0) |-> !raw);

    a_r4_ceiling: assert property (@(posedge clk) disable iff (rst)
        (cmp_act >= period) |-> raw);

    a_r5_zero: assert property (@(posedge clk) disable iff (rst)
        ez |-> cnt == '0);

    a_r5_peak: assert property (@(posedge clk) disable iff (rst)
        ep |-> cnt == period);

    a_r6_rise_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(hi) |-> gap_q >= {1'b0, rise_dly});

    a_r7_fall_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(lo) |-> gap_q >= {1'b0, fall_dly});

    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(hi && lo));

    a_r10_reset: assert property (@(posedge clk)
        $past(rst) |-> (!hi && !lo && !ez && !ep && cnt == '0));

endmodule

bind cpwm_leg cpwm_leg_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .period   (period_i),
    .cnt      (cnt_w),
    .cmp_act  (cmp_act_w),
    .rise_dly (rise_dly_i),
    .fall_dly (fall_dly_i),
    .raw      (raw_w),
    .hi       (gate_hi_o),
    .lo       (gate_lo_o),
    .ez       (evt_zero_o),
    .ep       (evt_peak_o)
);

// File: tb/cpwm_leg_bench.sv
module cpwm_leg_bench;
    import cpwm_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst;
    logic [CNT_W-1:0] period_i, cmp_i;
    logic [DIV_W-1:0] base_div, hs_div;
    logic [DB_W-1:0]  rise_dly, fall_dly;
    logic             gate_hi, gate_lo, evt_zero, evt_peak;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpwm_leg u_cpwm_leg (
        .clk        (clk),
        .rst        (rst),
        .period_i   (period_i),
        .base_div_i (base_div),
        .hs_div_i   (hs_div),
        .cmp_i      (cmp_i),
        .rise_dly_i (rise_dly),
        .fall_dly_i (fall_dly),
        .gate_hi_o  (gate_hi),
        .gate_lo_o  (gate_lo),
        .evt_zero_o (evt_zero),
        .evt_peak_o (evt_peak)
    );

    typedef struct {
        int   k;
        logic hi;
        logic lo;
        logic ez;
        logic ep;
    } exp_t;

    exp_t  sb_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    int    k_cnt = 0;
    string seg_tag = "";
    int    g_p = 1, g_d = 1, g_c1 = 0, g_c2 = 0, g_kc = 1 << 30, g_dbr = 0, g_dbf = 0;

    // Raw pulse after clock edge k, from R1 to R4
    function automatic bit raw_at(int k);
        int t, r, c, cnt, ld;
        t = k / g_d;
        if (t < 2 * g_p) return 1'b0;
        ld  = (t / (2 * g_p)) * (2 * g_p) * g_d;
        c   = (ld > g_kc) ? g_c2 : g_c1;
        r   = t % (2 * g_p);
        cnt = (r <= g_p) ? r : 2 * g_p - r;
        return (c >= g_p) || (cnt < c);
    endfunction

    // R6: raw high for the last rise_dly+1 edges
    function automatic bit hi_at(int k);
        if (k - 1 - g_dbr < 0) return 1'b0;
        for (int j = k - 1 - g_dbr; j <= k - 1; j++)
            if (!raw_at(j)) return 1'b0;
        return 1'b1;
    endfunction

    // R7: raw low for the last fall_dly+1 edges
    function automatic bit lo_at(int k);
        if (k - 1 - g_dbf < 0) return 1'b0;
        for (int j = k - 1 - g_dbf; j <= k - 1; j++)
            if (raw_at(j)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit ez_at(int k);
        if (k < 1 || (k % g_d) != 0) return 1'b0;
        return ((k / g_d) % (2 * g_p)) == 0;
    endfunction

    function automatic bit ep_at(int k);
        if (k < 1 || (k % g_d) != 0) return 1'b0;
        return ((k / g_d) % (2 * g_p)) == g_p;
    endfunction

    task automatic miss(string req, string what, logic act, logic expv);
        n_bad++;
        $display("FAIL %s [%s] cycle %0d %s=%0b expected %0b", req, seg_tag, k_cnt, what, act, expv);
    endtask

    always @(posedge clk) begin
        if (rst) k_cnt <= 0;
        else     k_cnt <= k_cnt + 1;
    end

    // Monitor: pops the expected item for the current cycle and compares
    always @(negedge clk) begin : mon
        exp_t e;
        if (!rst && sb_q.size() > 0 && sb_q[0].k == k_cnt) begin
            e = sb_q.pop_front();
            n_vec++;
            if (gate_hi !== e.hi)   miss("R6", "gate_hi", gate_hi, e.hi);
            if (gate_lo !== e.lo)   miss("R7", "gate_lo", gate_lo, e.lo);
            if (evt_zero !== e.ez)  miss("R5", "evt_zero", evt_zero, e.ez);
            if (evt_peak !== e.ep)  miss("R5", "evt_peak", evt_peak, e.ep);
            if (gate_hi && gate_lo) miss("R8", "overlap", 1'b1, 1'b0);
        end
    end

    // Driver: configure under reset, push expected items, release, wait for drain
    task automatic run_seg(string tag, int p, int cd, int hd, int c1, int c2, int kc,
                           int dbr, int dbf, int n);
        @(negedge clk);
        rst      = 1'b1;
        seg_tag  = tag;
        period_i = CNT_W'(p);
        base_div = DIV_W'(cd);
        hs_div   = DIV_W'(hd);
        cmp_i    = CNT_W'(c1);
        rise_dly = DB_W'(dbr);
        fall_dly = DB_W'(dbf);
        g_p = p; g_d = (cd + 1) * (hd + 1); g_c1 = c1; g_c2 = c2; g_kc = kc;
        g_dbr = dbr; g_dbf = dbf;
        repeat (2) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (gate_hi !== 1'b0 || gate_lo !== 1'b0 || evt_zero !== 1'b0 || evt_peak !== 1'b0)
            miss("R10", "outputs_or", gate_hi | gate_lo | evt_zero | evt_peak, 1'b0);
        for (int k = 1; k <= n; k++)
            sb_q.push_back('{k, hi_at(k), lo_at(k), ez_at(k), ep_at(k)});
        rst = 1'b0;
        if (kc < n) begin
            repeat (kc) @(posedge clk);
            @(negedge clk);
            cmp_i = CNT_W'(c2);
        end
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 [%s] watchdog expired at cycle %0d, expected completion", seg_tag, k_cnt);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        rst = 1'b1;
        period_i = '0; cmp_i = '0; base_div = '0; hs_div = '0;
        rise_dly = '0; fall_dly = '0;
        // R1 R4 R6 R7: 50 kHz carrier, 500 ns dead time
        run_seg("R1 R6 R7 50k", 1500, 0, 0, 600, 600, 1 << 30, 75, 75, 6200);
        // R2: cascaded dividers, ratio 3 x 2
        run_seg("R2 prescale", 20, 2, 1, 7, 7, 1 << 30, 3, 5, 720);
        // R3: compare changed mid-cycle, takes effect only at the next zero
        run_seg("R3 shadow", 10, 0, 0, 3, 8, 25, 1, 2, 100);
        // R4: compare of zero keeps the low side on
        run_seg("R4 zero cmp", 10, 0, 0, 0, 0, 1 << 30, 2, 4, 80);
        // R4: compare equal to the peak keeps the high side on
        run_seg("R4 cmp at peak", 10, 0, 0, 10, 10, 1 << 30, 2, 4, 80);
        // R4: compare above the peak
        run_seg("R4 cmp above", 10, 0, 0, 25, 25, 1 << 30, 3, 1, 80);
        // R9: raw pulse narrower than the turn-on delay is swallowed
        run_seg("R9 narrow", 10, 0, 0, 2, 2, 1 << 30, 5, 3, 100);
        // R6 R7: zero dead time
        run_seg("R6 R7 no dead", 8, 0, 0, 4, 4, 1 << 30, 0, 0, 60);
        // R1: 10 kHz carrier
        run_seg("R1 10k", 7500, 0, 0, 3000, 3000, 1 << 30, 75, 75, 15300);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule